// File: doc/BRIEF.md
# GPIO Controller with Edge-Detect Interrupts

This block is a 28-pin general-purpose I/O peripheral that sits on a simple 32-bit register bus. Software configures each pin as an input or an output. It drives output pins through a pair of write-one registers, one for set and one for clear, so no read-modify-write sequence is needed. The live level of every pin can be read back at any time.

Every pin can watch for rising edges, falling edges, or both. Each detected edge is held in a status register until software clears it by writing ones. Pins 0 to 10 each raise their own interrupt line. Pins 11 to 27 share one interrupt line. An extra 28-bit storage register is provided for pin-function selection logic outside this block.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset all pins are inputs (`pin_oe_o` = 0), the output latch is 0, and the enable, status and function registers read 0. Every interrupt output is low.
- R2: Word 1 holds the direction. A bit of 1 makes that pin an output, and `pin_oe_o` follows the register.
- R3: Writing word 2 sets each latch bit written as 1 and leaves bits written as 0 alone. Word 2 reads as 0.
- R4: Writing word 3 clears each latch bit written as 1 and leaves bits written as 0 alone. Word 3 reads as 0.
- R5: Word 0 returns each pin's level through a two-stage synchronizer, whatever the pin's direction. Writes to word 0 are ignored. Bits 31:28 of every register read as 0.
- R6: With its bit set in word 4, a rising edge on a pin sets that pin's status bit. This happens at the third clock edge after the input changes.
- R7: With its bit set in word 5, a falling edge sets the status bit in the same way. With both enables set, either edge is detected.
- R8: An edge on a pin whose two enables are both 0 leaves its status bit at 0.
- R9: Word 6 holds the edge status. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and writing all ones clears every pending bit.
- R10: If an edge is detected in the same cycle that software writes 1 to clear that bit, the bit stays set.
- R11: `irq_pin_o[n]` equals status bit n for n = 0 to 10. `irq_shared_o` is the OR of status bits 11 to 27.
- R12: Word 7 is plain read/write storage and has no effect on the pins, the status or the interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_in_i | input | 28 | Pad input levels |
| pin_out_o | output | 28 | Output latch |
| pin_oe_o | output | 28 | Output enable (direction) |
| irq_pin_o | output | 11 | Per-pin interrupts, pins 0 to 10 |
| irq_shared_o | output | 1 | Shared interrupt, pins 11 to 27 |

## Verification
The bench loops the pads back, so an output pin is read on its own input. Any fault in the direction register or the output latch therefore shows up twice: in the level read-back and as spurious edges in the status, within three cycles of the write. A wrong edge-enable or synchronizer stage shows up as a status bit that is set, missing, or a cycle late, and as the matching interrupt line. The bench catches this at the read that follows each settle window. A wrong clear-versus-edge priority shows only in the directed collision cycle, where the bit that should survive reads back as cleared.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int NPIN = 28;
  localparam int NDED = 11;
  localparam int DW   = 32;

  typedef enum logic [2:0] {
    RG_LEVEL = 3'd0,
    RG_DIR   = 3'd1,
    RG_SET   = 3'd2,
    RG_CLR   = 3'd3,
    RG_RISE  = 3'd4,
    RG_FALL  = 3'd5,
    RG_STAT  = 3'd6,
    RG_ALT   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int NP = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [NP-1:0] wdata_i,
  output logic [NP-1:0] dir_o,
  output logic [NP-1:0] out_o,
  output logic [NP-1:0] rise_o,
  output logic [NP-1:0] fall_o,
  output logic [NP-1:0] alt_o
);
  logic [NP-1:0] dir_q, out_q, rise_q, fall_q, alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        RG_DIR:  dir_q  <= wdata_i;
        RG_SET:  out_q  <= out_q | wdata_i;
        RG_CLR:  out_q  <= out_q & ~wdata_i;
        RG_RISE: rise_q <= wdata_i;
        RG_FALL: fall_q <= wdata_i;
        RG_ALT:  alt_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign alt_o  = alt_q;

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == RG_SET) |=>
      ((out_q & $past(wdata_i)) == $past(wdata_i)) &&
      ((out_q & ~$past(wdata_i)) == ($past(out_q) & ~$past(wdata_i))));

  assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == RG_CLR) |=>
      ((out_q & $past(wdata_i)) == '0) &&
      ((out_q & ~$past(wdata_i)) == ($past(out_q) & ~$past(wdata_i))));

  assert_dir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_i == RG_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int NP = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] level_i,
  input  logic [NP-1:0] rise_en_i,
  input  logic [NP-1:0] fall_en_i,
  input  logic [NP-1:0] clr_i,
  output logic [NP-1:0] status_o
);
  logic [NP-1:0] prev_q, status_q, hit;

  assign hit = (rise_en_i & level_i & ~prev_q) | (fall_en_i & ~level_i & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level_i;
      // a fresh edge beats a simultaneous clear
      status_q <= (status_q & ~clr_i) | hit;
    end
  end

  assign status_o = status_q;

  assert_edge_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(hit)) == '0));

  assert_collide_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit & clr_i) != '0) |=> ((status_q & $past(hit & clr_i)) == $past(hit & clr_i)));

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~hit) != '0) |=> ((status_q & $past(clr_i & ~hit)) == '0));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int NP = 28,
  parameter int ND = 11
) (
  input  logic [NP-1:0] status_i,
  output logic [ND-1:0] irq_pin_o,
  output logic          irq_shared_o
);
  for (genvar n = 0; n < ND; n++) begin : g_ded
    assign irq_pin_o[n] = status_i[n];
  end

  assign irq_shared_o = |status_i[NP-1:ND];
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NP = NPIN,
  parameter int ND = NDED,
  parameter int BW = DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  input  logic [NP-1:0] pin_in_i,
  output logic [NP-1:0] pin_out_o,
  output logic [NP-1:0] pin_oe_o,
  output logic [ND-1:0] irq_pin_o,
  output logic          irq_shared_o
);
  localparam int PADW = BW - NP;

  reg_sel_e      sel;
  logic          wr;
  logic [NP-1:0] wd, level, dir, outl, rise, fall, alt, status, clr;
  logic [NP-1:0] rd;
  logic          unused_hi;

  assign sel       = reg_sel_e'(addr_i);
  assign wr        = req_i & we_i;
  assign wd        = wdata_i[NP-1:0];
  assign unused_hi = ^wdata_i[BW-1:NP];
  assign clr       = (wr && sel == RG_STAT) ? wd : '0;

  gpio_sync #(.W(NP)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (level)
  );

  gpio_regs #(.NP(NP)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .sel_i  (sel),
    .wdata_i(wd),
    .dir_o  (dir),
    .out_o  (outl),
    .rise_o (rise),
    .fall_o (fall),
    .alt_o  (alt)
  );

  gpio_edge #(.NP(NP)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level),
    .rise_en_i(rise),
    .fall_en_i(fall),
    .clr_i    (clr),
    .status_o (status)
  );

  gpio_irq #(.NP(NP), .ND(ND)) u_irq (
    .status_i    (status),
    .irq_pin_o   (irq_pin_o),
    .irq_shared_o(irq_shared_o)
  );

  always_comb begin
    unique case (sel)
      RG_LEVEL: rd = level;
      RG_DIR:   rd = dir;
      RG_RISE:  rd = rise;
      RG_FALL:  rd = fall;
      RG_STAT:  rd = status;
      RG_ALT:   rd = alt;
      default:  rd = '0;
    endcase
  end

  assign rdata_o   = {{PADW{1'b0}}, rd};
  assign pin_out_o = outl;
  assign pin_oe_o  = dir;

  assert_level_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pin_in_i) |=> ##1 (level == $past(pin_in_i, 2)));
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [31:0] wdata_i = 32'd0;
  logic [31:0] rdata_o;
  logic [27:0] pin_in_i, pin_out_o, pin_oe_o;
  logic [10:0] irq_pin_o;
  logic        irq_shared_o;

  logic [27:0] ext = 28'd0;
  logic [27:0] m_dir = '0, m_out = '0, m_rise = '0, m_fall = '0, m_stat = '0, m_alt = '0;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  assign pin_in_i = (pin_oe_o & pin_out_o) | (~pin_oe_o & ext);

  gpio_edge_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_in_i(pin_in_i), .pin_out_o(pin_out_o),
    .pin_oe_o(pin_oe_o), .irq_pin_o(irq_pin_o), .irq_shared_o(irq_shared_o)
  );

  function automatic logic [27:0] pad_exp();
    return (m_dir & m_out) | (~m_dir & ext);
  endfunction

  function automatic logic [27:0] edges_exp(input logic [27:0] o, input logic [27:0] n);
    return (~o & n & m_rise) | (o & ~n & m_fall);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = idx; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = idx;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic settle(input logic [27:0] o, input logic [27:0] n);
    repeat (4) @(negedge clk_i);
    m_stat = m_stat | edges_exp(o, n);
  endtask

  task automatic apply_write(input logic [2:0] idx, input logic [31:0] d);
    logic [27:0] o, n;
    o = pad_exp();
    bus_wr(idx, d);
    case (idx)
      3'd1: m_dir  = d[27:0];
      3'd2: m_out  = m_out | d[27:0];
      3'd3: m_out  = m_out & ~d[27:0];
      3'd4: m_rise = d[27:0];
      3'd5: m_fall = d[27:0];
      3'd6: m_stat = m_stat & ~d[27:0];
      3'd7: m_alt  = d[27:0];
      default: ;
    endcase
    n = pad_exp();
    settle(o, n);
  endtask

  task automatic set_ext(input logic [27:0] v);
    logic [27:0] o;
    o = pad_exp();
    @(negedge clk_i);
    ext = v;
    settle(o, pad_exp());
  endtask

  task automatic chk_all();
    logic [31:0] r;
    bus_rd(3'd0, r); chk("R5 level", r, {4'd0, pad_exp()});
    bus_rd(3'd1, r); chk("R2 dir", r, {4'd0, m_dir});
    bus_rd(3'd2, r); chk("R3 set reads 0", r, 32'd0);
    bus_rd(3'd3, r); chk("R4 clr reads 0", r, 32'd0);
    bus_rd(3'd4, r); chk("R6 rise en", r, {4'd0, m_rise});
    bus_rd(3'd5, r); chk("R7 fall en", r, {4'd0, m_fall});
    bus_rd(3'd6, r); chk("R9 status", r, {4'd0, m_stat});
    bus_rd(3'd7, r); chk("R12 alt", r, {4'd0, m_alt});
    chk("R2 pin_oe", {4'd0, pin_oe_o}, {4'd0, m_dir});
    chk("R3 R4 pin_out", {4'd0, pin_out_o}, {4'd0, m_out});
    chk("R11 irq_pin", {21'd0, irq_pin_o}, {21'd0, m_stat[10:0]});
    chk("R11 irq_shared", {31'd0, irq_shared_o}, {31'd0, |m_stat[27:11]});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4711));
    ext = 28'h5A5_3C71;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 irq_pin", {21'd0, irq_pin_o}, 32'd0);
    chk("R1 irq_shared", {31'd0, irq_shared_o}, 32'd0);
    chk("R1 pin_oe", {4'd0, pin_oe_o}, 32'd0);
    chk("R1 pin_out", {4'd0, pin_out_o}, 32'd0);
    chk_all();

    // R8: enables off, toggling pins leaves status clear
    set_ext(~ext);
    bus_rd(3'd6, r); chk("R8 no enable", r, 32'd0);

    // R5: level write ignored
    apply_write(3'd0, 32'hFFFF_FFFF);
    chk_all();

    // R6/R7/R11: directed edges on a dedicated and a shared pin
    apply_write(3'd4, 32'h0000_0021);
    apply_write(3'd5, 32'h0010_0001);
    set_ext(28'd0);
    set_ext(28'h010_0021);
    chk_all();
    set_ext(28'd0);
    chk_all();
    bus_rd(3'd6, r); chk("R7 fall pin20", {31'd0, r[20]}, 32'd1);

    // R9: all-ones clears everything
    apply_write(3'd6, 32'hFFFF_FFFF);
    bus_rd(3'd6, r); chk("R9 clear all", r, 32'd0);

    // R10: edge in the same cycle as its clear
    apply_write(3'd4, 32'h0FFF_FFFF);
    apply_write(3'd5, 32'd0);
    set_ext(28'h000_0014);
    set_ext(28'h000_0010);
    @(negedge clk_i);
    ext = 28'h000_0014;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 3'd6; wdata_i = 32'h0000_0014;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    m_stat = (m_stat & ~28'h000_0014) | 28'h000_0004;
    repeat (3) @(negedge clk_i);
    bus_rd(3'd6, r);
    chk("R10 edge wins", {31'd0, r[2]}, 32'd1);
    chk("R9 other bit cleared", {31'd0, r[4]}, 32'd0);
    chk_all();

    // R12: alt has no effect on pins or status
    apply_write(3'd7, 32'h0ABC_DEF1);
    chk_all();

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 9);
      if (op == 8 || op == 0) set_ext($urandom);
      else apply_write(op[2:0], $urandom);
      chk_all();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule